// File: doc/BRIEF.md
# Fractional Dot-Product Accumulate Unit

The unit takes two 32-bit words, each holding two signed Q15 lanes, and folds their fractional dot product into one of four 64-bit accumulators. Each lane product is the signed 16x16 product doubled into a Q31 value. The two lane products are summed and then added to the chosen accumulator, or subtracted from it. Lanes can pair straight (lane i with lane i) or crossed. In crossed mode, lane i of the second word meets the mirror lane of the first word. The pair of most-negative inputs cannot be represented once doubled. That lane instead contributes the maximum of the selected output format and reports an overflow.

When post-saturation is enabled, the new accumulator value is clamped. In 64-bit format the clamp uses a sign-based wrap test. In 32-bit Q31 format the value is held to the signed 32-bit range. Every overflow sets a sticky flag belonging to the accumulator that was written. The flag stays set until reset. A read port returns any accumulator at any time.

Requests arrive on a valid/ready interface. Ready is low while reset is asserted and goes high on the first clock edge after reset is released. It then stays high, so a request is accepted in every cycle in which valid is high and there is no back-pressure. The new accumulator value and the overflow bit of the accepted request appear on the result port for exactly one cycle after the accepting edge.

Top module: `frac_dot_mac`

## Requirements
- R1: While reset is low, and directly after reset, all four accumulators read zero, all overflow flags are zero and `res_valid` is low.
- R2: The contribution of lane i is 2 x a_i x b_i, where lane 0 is bits 15:0 and lane 1 is bits 31:16 of each word, both signed. With `in_xchg`=0, the two contributions are summed and, with `in_sub`=0, added to accumulator `in_sel`.
- R3: With `in_xchg`=1, lane i of `in_b` is multiplied by lane (1-i) of `in_a`.
- R4: If both operands of a lane equal 0x8000, that lane contributes 0x7FFF_FFFF_FFFF_FFFF when `in_q31`=0, or 0x7FFF_FFFF when `in_q31`=1, and `res_ovf` is 1.
- R5: With `in_sub`=1, the summed contributions are subtracted from the accumulator.
- R6: With `in_sat`=1 and `in_q31`=0, overflow is detected in one case only: the accumulator and the added term (the negated sum when subtracting) share a sign, and the sum's sign differs from it. The result is then 0x8000_0000_0000_0000 if the accumulator was negative, else 0x7FFF_FFFF_FFFF_FFFF, and `res_ovf` is 1.
- R7: With `in_sat`=1 and `in_q31`=1, a result above 2^31-1 or below -2^31 is clamped to that bound (sign-extended to 64 bits), and `res_ovf` is 1.
- R8: With `in_sat`=0, the accumulator wraps modulo 2^64, and `res_ovf` is 1 only in the R4 case.
- R9: `ovf_flags[k]` is set when a request to accumulator k overflows. It never clears before reset, and no other flag bit changes.
- R10: An accepted request updates its accumulator at that clock edge. `res_valid` is high for the following cycle only, with `res_acc` equal to the new value. When no request is accepted, no accumulator changes.
- R11: `rd_acc` always shows the accumulator selected by `rd_sel`, including a value written at the previous edge.
- R12: `in_ready` is low during reset and high from the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with valid |
| in_a | input | 32 | First operand, two Q15 lanes |
| in_b | input | 32 | Second operand, two Q15 lanes |
| in_sel | input | 2 | Accumulator to update |
| in_sub | input | 1 | 1 subtracts the dot product, 0 adds it |
| in_xchg | input | 1 | 1 pairs lanes crossed |
| in_sat | input | 1 | 1 enables post-saturation |
| in_q31 | input | 1 | 1 selects the 32-bit Q31 output format, 0 the 64-bit format |
| rd_sel | input | 2 | Accumulator shown on the read port |
| rd_acc | output | 64 | Read-port value |
| res_valid | output | 1 | Result valid, one cycle per accepted request |
| res_acc | output | 64 | New accumulator value |
| res_ovf | output | 1 | Overflow raised by that request |
| ovf_flags | output | 4 | Sticky overflow flag per accumulator |

## Verification
The bench aims at the 0x8000 x 0x8000 lane in both output formats. A design that doubled that product would wrap to -1.0 and leave the flag clear. It drives the 64-bit clamp in both directions, including a subtraction whose negated term carries the sign. A design testing the sign of the un-negated sum would miss the wrap or clamp the wrong way. It also drives the Q31 clamp at both bounds and crossed pairing with unequal lanes, where a mirrored index shows up as a different sum. A random phase weighted toward 0x8000 and 0x7FFF catches flags raised on the wrong accumulator, and flags that clear on later requests.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  typedef struct packed {
    logic sub;
    logic xchg;
    logic sat;
    logic q31;
  } fdm_mode_t;

  function automatic logic [63:0] sext_lane(input logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction
endpackage

// File: rtl/fdm_lane_mul.sv
module fdm_lane_mul #(
  parameter int LANE_W = 16,
  parameter int ACC_W  = 64
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              q31,
  output logic [ACC_W-1:0]  prod,
  output logic              ovf
);
  localparam int PW = 2 * LANE_W;
  localparam logic [LANE_W-1:0] L_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] W_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] N_MAX = {{(ACC_W-PW+1){1'b0}}, {(PW-1){1'b1}}};

  logic signed [PW-1:0] raw;
  logic signed [PW-1:0] dbl;

  always_comb begin
    raw = $signed(a) * $signed(b);
    dbl = raw <<< 1;
    ovf = (a == L_MIN) && (b == L_MIN);
    if (ovf) prod = q31 ? N_MAX : W_MAX;
    else     prod = {{(ACC_W-PW){dbl[PW-1]}}, dbl};
  end
endmodule

// File: rtl/fdm_dot.sv
module fdm_dot #(
  parameter int LANES  = 2,
  parameter int LANE_W = 16,
  parameter int ACC_W  = 64
) (
  input  logic [LANES*LANE_W-1:0] a,
  input  logic [LANES*LANE_W-1:0] b,
  input  fdm_pkg::fdm_mode_t      mode,
  output logic [ACC_W-1:0]        term,
  output logic                    prod_ovf
);
  logic [LANES-1:0][ACC_W-1:0] prods;
  logic [LANES-1:0]            lane_ovf;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] a_pick;
    assign a_pick = mode.xchg ? a[(LANES-1-i)*LANE_W +: LANE_W]
                              : a[i*LANE_W +: LANE_W];
    fdm_lane_mul #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_mul (
      .a    (a_pick),
      .b    (b[i*LANE_W +: LANE_W]),
      .q31  (mode.q31),
      .prod (prods[i]),
      .ovf  (lane_ovf[i])
    );
  end

  logic [ACC_W-1:0] total;
  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) total = total + prods[i];
    term     = mode.sub ? (~total + 1'b1) : total;
    prod_ovf = |lane_ovf;
  end
endmodule

// File: rtl/fdm_acc_sat.sv
module fdm_acc_sat #(
  parameter int ACC_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk,
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] term,
  input  logic             sat,
  input  logic             q31,
  output logic [ACC_W-1:0] nxt,
  output logic             ovf
);
  localparam int MSB = ACC_W - 1;
  localparam logic [ACC_W-1:0] W_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] W_MIN = ~W_MAX;
  localparam logic [ACC_W-1:0] N_MAX = {{(ACC_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] N_MIN = ~N_MAX;

  logic [ACC_W-1:0] sum;
  logic wide_wrap, above, below;

  always_comb begin
    sum       = acc + term;
    wide_wrap = (acc[MSB] == term[MSB]) && (sum[MSB] != acc[MSB]);
    above     = $signed(sum) > $signed(N_MAX);
    below     = $signed(sum) < $signed(N_MIN);
    nxt = sum;
    ovf = 1'b0;
    if (sat) begin
      if (!q31) begin
        if (wide_wrap) begin
          ovf = 1'b1;
          nxt = acc[MSB] ? W_MIN : W_MAX;
        end
      end else if (above) begin
        ovf = 1'b1;
        nxt = N_MAX;
      end else if (below) begin
        ovf = 1'b1;
        nxt = N_MIN;
      end
    end
  end

  assert_q31_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && sat && q31) |-> ($signed(nxt) <= $signed(N_MAX) && $signed(nxt) >= $signed(N_MIN)));

  assert_wide_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && sat && !q31 && acc[MSB] == term[MSB]) |-> (nxt[MSB] == acc[MSB]));

  assert_nosat_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && !sat) |-> !ovf);
endmodule

// File: rtl/fdm_acc_bank.sv
module fdm_acc_bank #(
  parameter int N_ACC = 4,
  parameter int ACC_W = 64,
  localparam int SEL_W = $clog2(N_ACC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             wr_ovf,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [ACC_W-1:0] rd_data,
  output logic [ACC_W-1:0] sel_data,
  output logic [N_ACC-1:0] flags
);
  logic [N_ACC-1:0][ACC_W-1:0] acc_q;
  logic [N_ACC-1:0]            flag_q;

  for (genvar k = 0; k < N_ACC; k++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[k]  <= '0;
        flag_q[k] <= 1'b0;
      end else if (wr_en && wr_sel == SEL_W'(k)) begin
        acc_q[k] <= wr_data;
        if (wr_ovf) flag_q[k] <= 1'b1;
      end
    end
  end

  assign rd_data  = acc_q[rd_sel];
  assign sel_data = acc_q[wr_sel];
  assign flags    = flag_q;

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  assert_flag_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(flag_q ^ $past(flag_q)) <= 1));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(acc_q));
endmodule

// File: rtl/frac_dot_mac.sv
module frac_dot_mac #(
  parameter int LANES  = 2,
  parameter int LANE_W = 16,
  parameter int N_ACC  = 4,
  parameter int ACC_W  = 64,
  localparam int WORD_W = LANES * LANE_W,
  localparam int SEL_W  = $clog2(N_ACC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic              in_sub,
  input  logic              in_xchg,
  input  logic              in_sat,
  input  logic              in_q31,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ACC_W-1:0]  rd_acc,
  output logic              res_valid,
  output logic [ACC_W-1:0]  res_acc,
  output logic              res_ovf,
  output logic [N_ACC-1:0]  ovf_flags
);
  import fdm_pkg::*;

  localparam logic [LANE_W-1:0] L_MIN = {1'b1, {(LANE_W-1){1'b0}}};

  fdm_mode_t        mode;
  logic             rdy_q, fire;
  logic [ACC_W-1:0] term, cur, nxt;
  logic             prod_ovf, sat_ovf, any_ovf;

  assign mode     = '{sub: in_sub, xchg: in_xchg, sat: in_sat, q31: in_q31};
  assign in_ready = rdy_q;
  assign fire     = in_valid && rdy_q;
  assign any_ovf  = prod_ovf || sat_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  fdm_dot #(.LANES(LANES), .LANE_W(LANE_W), .ACC_W(ACC_W)) u_dot (
    .a(in_a), .b(in_b), .mode(mode), .term(term), .prod_ovf(prod_ovf)
  );

  fdm_acc_sat #(.ACC_W(ACC_W), .NARROW_W(2*LANE_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .chk(fire), .acc(cur), .term(term),
    .sat(in_sat), .q31(in_q31), .nxt(nxt), .ovf(sat_ovf)
  );

  fdm_acc_bank #(.N_ACC(N_ACC), .ACC_W(ACC_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(fire), .wr_sel(in_sel), .wr_data(nxt),
    .wr_ovf(any_ovf), .rd_sel(rd_sel), .rd_data(rd_acc), .sel_data(cur),
    .flags(ovf_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_acc   <= '0;
      res_ovf   <= 1'b0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_acc <= nxt;
        res_ovf <= any_ovf;
      end
    end
  end

  assert_res_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(fire));

  assert_minmin_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_xchg && in_a[LANE_W-1:0] == L_MIN && in_b[LANE_W-1:0] == L_MIN)
      |=> res_ovf);
endmodule

// File: tb/test_frac_dot_mac.sv
`timescale 1ns/1ps
module test_frac_dot_mac;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sub = 0, in_xchg = 0, in_sat = 0, in_q31 = 0;
  logic [31:0] in_a = 0, in_b = 0;
  logic [1:0] in_sel = 0, rd_sel = 0;
  logic in_ready, res_valid, res_ovf;
  logic [63:0] rd_acc, res_acc;
  logic [3:0] ovf_flags;

  int checks = 0, errors = 0, cyc = 0;
  longint m_acc[4];
  bit [3:0] m_flag;
  bit m_rv, m_rovf, m_rdy;
  longint m_racc;

  always #2 clk = ~clk;

  frac_dot_mac i_frac_dot_mac (.*);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic void model_op(input logic [31:0] a, b, input bit sub, xchg, sat, q31,
                                   input longint acc, output longint nv, output bit ov);
    longint s = 0, term, sum;
    ov = 0;
    for (int i = 0; i < 2; i++) begin
      longint ai, bi;
      ai = longint'($signed(xchg ? a[16*(1-i) +: 16] : a[16*i +: 16]));
      bi = longint'($signed(b[16*i +: 16]));
      if (ai == -32768 && bi == -32768) begin
        s += q31 ? 64'sh7FFF_FFFF : 64'sh7FFF_FFFF_FFFF_FFFF;
        ov = 1;
      end else s += ai * bi * 2;
    end
    term = sub ? -s : s;
    sum = acc + term;
    nv = sum;
    if (sat) begin
      if (!q31) begin
        if (acc[63] == term[63] && sum[63] != acc[63]) begin
          ov = 1;
          nv = acc[63] ? 64'sh8000_0000_0000_0000 : 64'sh7FFF_FFFF_FFFF_FFFF;
        end
      end else if (sum > 64'sd2147483647) begin ov = 1; nv = 64'sd2147483647; end
      else if (sum < -64'sd2147483648) begin ov = 1; nv = -64'sd2147483648; end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_acc[k] <= 0;
      m_flag <= 0; m_rv <= 0; m_rdy <= 0; m_racc <= 0; m_rovf <= 0;
    end else begin
      m_rdy <= 1;
      m_rv <= in_valid && m_rdy;
      if (in_valid && m_rdy) begin
        longint nv; bit ov;
        model_op(in_a, in_b, in_sub, in_xchg, in_sat, in_q31, m_acc[in_sel], nv, ov);
        m_acc[in_sel] <= nv;
        m_racc <= nv; m_rovf <= ov;
        if (ov) m_flag[in_sel] <= 1;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R10 res_valid", res_valid, m_rv);
      if (m_rv) begin
        chk("R10 res_acc", res_acc, m_racc);
        chk("R8 res_ovf", res_ovf, m_rovf);
      end
      chk("R9 flags", ovf_flags, m_flag);
      chk("R11 rd_acc", rd_acc, m_acc[rd_sel]);
      chk("R12 ready", in_ready, m_rdy);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_op(logic [31:0] a, b, logic [1:0] sel, bit sub, xchg, sat, q31);
    @(negedge clk);
    in_valid = 1; in_a = a; in_b = b; in_sel = sel;
    in_sub = sub; in_xchg = xchg; in_sat = sat; in_q31 = q31; rd_sel = sel;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [15:0] pick16();
    case ($urandom % 4)
      0: return 16'h8000;
      1: return 16'h7FFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 ready in reset", in_ready, 0);
    chk("R1 res_valid in reset", res_valid, 0);
    chk("R1 flags in reset", ovf_flags, 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      rd_sel = 2'(k); #0.5;
      chk("R1 acc zero", rd_acc, 0);
    end
    chk("R12 ready", in_ready, 1);

    do_op(32'h4000_4000, 32'h4000_4000, 0, 0, 0, 0, 0);
    chk("R2 straight sum", res_acc, 64'h4000_0000);
    do_op(32'h4000_2000, 32'h0000_4000, 1, 0, 1, 0, 0);
    chk("R3 crossed", res_acc, 64'h2000_0000);
    do_op(32'h8000_8000, 32'h8000_8000, 2, 0, 0, 0, 1);
    chk("R4 q31 max", res_acc, 64'hFFFF_FFFE);
    chk("R4 ovf", res_ovf, 1);
    chk("R9 flag2", ovf_flags, 4'b0100);
    do_op(32'h4000_4000, 32'h4000_4000, 0, 1, 0, 0, 0);
    chk("R5 subtract", res_acc, 0);
    do_op(32'h0000_8000, 32'h0000_8000, 3, 0, 0, 0, 0);
    chk("R4 wide max", res_acc, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R9 flag3", ovf_flags, 4'b1100);
    do_op(32'h4000_4000, 32'h4000_4000, 3, 0, 0, 1, 0);
    chk("R6 clamp max", res_acc, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R6 ovf", res_ovf, 1);
    do_op(32'h4000_4000, 32'h4000_4000, 3, 0, 0, 0, 0);
    chk("R8 wrap", res_acc, 64'h8000_0000_3FFF_FFFF);
    chk("R8 no ovf", res_ovf, 0);
    do_op(32'h0000_8000, 32'h0000_8000, 3, 1, 0, 1, 0);
    chk("R6 clamp min via sub", res_acc, 64'h8000_0000_0000_0000);
    do_op(32'h7FFF_7FFF, 32'h7FFF_7FFF, 1, 0, 0, 1, 1);
    chk("R7 clamp high", res_acc, 64'h7FFF_FFFF);
    chk("R7 ovf", res_ovf, 1);
    do_op(32'h7FFF_7FFF, 32'h7FFF_7FFF, 1, 1, 0, 1, 1);
    chk("R7 in range", res_acc, 64'hFFFF_FFFF_8003_FFFB);
    chk("R7 no ovf", res_ovf, 0);
    do_op(32'h7FFF_7FFF, 32'h7FFF_7FFF, 1, 1, 0, 1, 1);
    chk("R7 clamp low", res_acc, 64'hFFFF_FFFF_8000_0000);
    do_op(32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0, 0);
    chk("R9 sticky kept", ovf_flags, 4'b1110);

    @(negedge clk);
    in_a = 32'h1234_5678; in_b = 32'h7FFF_8000; in_sel = 2; rd_sel = 2;
    repeat (3) @(negedge clk);
    chk("R10 idle hold", rd_acc, 64'hFFFF_FFFE);
    chk("R10 idle no result", res_valid, 0);

    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      in_valid = ($urandom % 4) != 0;
      in_a = {pick16(), pick16()}; in_b = {pick16(), pick16()};
      in_sel = 2'($urandom); rd_sel = 2'($urandom);
      {in_sub, in_xchg, in_sat, in_q31} = 4'($urandom);
    end
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule